// File: doc/BRIEF.md
# Entropy Sample FIFO Controller

This block gathers random bits from 128 free-running ring oscillators and stores them as 64-bit words in a 64-entry buffer that a host drains one word at a time. A word is built in one of three ways. In the deterministic mode the oscillators are gated off and a conditioner stub mixes a fixed zero input, so the output is reproducible for testing. In the conditioned mode live oscillator samples go through the same conditioner. In the raw mode one group of eight oscillators is sampled in parallel for eight cycles and the bits are packed into a word without any mixing.

Production runs in the background whenever the block is enabled and the buffer has room, so every read that frees a slot causes a refill. After power-on reset a memory self-test writes and reads back every buffer entry. The host sees the result in a two-bit status field that reads zero once the test has finished and passed. A core reset input empties the buffer and drops any half-built word. A read that finds the buffer empty waits until a word arrives.

Top module: `entropy_fifo_ctrl`

## Requirements
- R1: After `rst_n` is released the buffer self-test runs for exactly 128 cycles. During this time `bist_status` reads 2'b10 (bit 1 = busy, bit 0 = fail) and nothing is produced or read. Afterwards `bist_status` reads 2'b00 on a healthy memory.
- R2: Mode code 2'b00 (deterministic) yields one word every 81 cycles. Every word equals the value obtained by 81 conditioner steps on an all-zero sample, starting from 64'h6A09E667F3BCC908.
- R3: Mode code 2'b01 (conditioned) yields one word every 81 cycles. The word is acc after 81 steps. Each step computes acc = rotate_left(acc,5) ^ s[63:0] ^ s[127:64] ^ 64'h9E3779B97F4A7C15, where s is the 128-bit oscillator sample of that cycle. The seed is the same as in R2.
- R4: Mode code 2'b10 (raw) yields one word every 8 cycles. Byte lane k (bits 8k+7..8k) holds oscillator `ctl_group`*8+k, with the sample of the t-th cycle of the word in bit 8k+t.
- R5: The first sample taken from the oscillators after they are switched on reads as zero. The oscillators are on when `ctl_en` is high and the mode is 2'b01 or 2'b10.
- R6: The buffer holds 64 words. It never holds more, and production pauses while it is full.
- R7: Each word read frees a slot that production fills again in the background. Words leave in the order they were built.
- R8: A pulse on `rd_req` is held pending until a word is available. `rd_valid` pulses for one cycle with the oldest word on `rd_data`, one cycle after the word is taken. While the buffer is empty `rd_valid` stays low.
- R9: A cycle with `core_rst` high empties the buffer, drops the partial word and any pending read, and switches the oscillators off for that cycle.
- R10: A change of `ctl_mode` or `ctl_group` discards the partial word. The cycle of the change is the first cycle of a new word.
- R11: With `ctl_en` low or mode code 2'b11, no word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts the self-test |
| ctl_en | input | 1 | Enables word production |
| ctl_mode | input | 2 | 00 deterministic, 01 conditioned, 10 raw, 11 idle |
| ctl_group | input | 4 | Oscillator group sampled in raw mode |
| core_rst | input | 1 | Synchronous core reset: empties buffer, drops partial word |
| osc_in | input | 128 | Ring oscillator bits, one per oscillator |
| rd_req | input | 1 | Read request pulse |
| rd_data | output | 64 | Word returned by a read |
| rd_valid | output | 1 | One-cycle strobe qualifying `rd_data` |
| bist_status | output | 2 | {busy, fail}; zero after a passing self-test |

## Verification
The refill path and the read path can act in the same cycle: a finished word is written while the oldest word is taken. The bench provokes this by filling the buffer in raw mode and then holding `rd_req` high with production still enabled. Pops then run every cycle while a new word lands every eight cycles. It judges the outcome by the total number of words read out before the buffer runs dry, which must equal 64 plus the number of words completed in the window. It also checks that the level never passes 64 or jumps by more than one.

// File: rtl/efc_pkg.sv
package efc_pkg;

  localparam int WORD_W = 64;

  typedef enum logic [1:0] {
    MODE_DET  = 2'b00,
    MODE_COND = 2'b01,
    MODE_RAW  = 2'b10,
    MODE_OFF  = 2'b11
  } efc_mode_e;

  localparam logic [WORD_W-1:0] COND_SEED = 64'h6A09_E667_F3BC_C908;
  localparam logic [WORD_W-1:0] COND_KEY  = 64'h9E37_79B9_7F4A_7C15;
  localparam logic [WORD_W-1:0] BIST_MASK = 64'hC3A5_5A3C_0FF0_9669;

  // one conditioner step: rotate by five, mix in the folded sample and key
  function automatic logic [WORD_W-1:0] cond_step(input logic [WORD_W-1:0] acc,
                                                  input logic [WORD_W-1:0] folded);
    return {acc[WORD_W-6:0], acc[WORD_W-1:WORD_W-5]} ^ folded ^ COND_KEY;
  endfunction

  // self-test pattern stored at a buffer address
  function automatic logic [WORD_W-1:0] bist_pattern(input logic [7:0] idx);
    return {8{idx}} ^ BIST_MASK;
  endfunction

endpackage

// File: rtl/efc_osc_sampler.sv
module efc_osc_sampler #(
  parameter int N_OSC = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_on,
  input  logic [N_OSC-1:0] osc_in,
  output logic [N_OSC-1:0] sample,
  output logic             osc_live
);

  // osc_live trails osc_on by a cycle so the first sample after switch-on is zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_live <= 1'b0;
    else        osc_live <= osc_on;
  end

  assign sample = (osc_live && osc_on) ? osc_in : '0;

endmodule

// File: rtl/efc_entry_builder.sv
module efc_entry_builder
  import efc_pkg::*;
#(
  parameter int N_OSC       = 128,
  parameter int GROUP_W     = 8,
  parameter int COND_CYCLES = 81,
  parameter int GRP_IDX_W   = $clog2(N_OSC / GROUP_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 run,
  input  efc_mode_e            mode,
  input  logic [GRP_IDX_W-1:0] group,
  input  logic [N_OSC-1:0]     sample,
  output logic                 push,
  output logic [WORD_W-1:0]    push_data,
  output logic                 restart
);

  localparam int RAW_CYCLES = GROUP_W;
  localparam int CNT_W      = $clog2(COND_CYCLES);
  localparam int SLOT_W     = $clog2(GROUP_W);
  localparam int N_FOLD     = N_OSC / WORD_W;

  efc_mode_e             mode_q;
  logic [GRP_IDX_W-1:0]  group_q;
  logic [CNT_W-1:0]      cnt, cnt_eff, len_m1;
  logic [WORD_W-1:0]     acc, acc_next, raw_acc, raw_next;
  logic [WORD_W-1:0]     folded;
  logic [GROUP_W-1:0]    lanes;
  logic                  last;

  // fold the oscillator vector into one word
  logic [WORD_W-1:0] fold_part [N_FOLD+1];
  assign fold_part[0] = '0;
  for (genvar gi = 0; gi < N_FOLD; gi++) begin : g_fold
    assign fold_part[gi+1] = fold_part[gi] ^ sample[gi*WORD_W +: WORD_W];
  end
  assign folded = fold_part[N_FOLD];

  assign lanes   = sample[group*GROUP_W +: GROUP_W];
  assign restart = (mode != mode_q) || (group != group_q);
  assign cnt_eff = restart ? '0 : cnt;
  assign len_m1  = (mode == MODE_RAW) ? CNT_W'(RAW_CYCLES - 1) : CNT_W'(COND_CYCLES - 1);
  assign last    = (cnt_eff == len_m1);

  assign acc_next = cond_step((cnt_eff == '0) ? COND_SEED : acc, folded);

  always_comb begin
    raw_next = (cnt_eff == '0) ? '0 : raw_acc;
    for (int k = 0; k < GROUP_W; k++) begin
      raw_next[k*GROUP_W + int'(cnt_eff[SLOT_W-1:0])] = lanes[k];
    end
  end

  assign push      = run && last;
  assign push_data = (mode == MODE_RAW) ? raw_next : acc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      group_q <= '0;
      cnt     <= '0;
      acc     <= '0;
      raw_acc <= '0;
    end else begin
      mode_q  <= mode;
      group_q <= group;
      if (clear || !run || last) cnt <= '0;
      else                      cnt <= cnt_eff + 1'b1;
      if (run) begin
        acc     <= acc_next;
        raw_acc <= raw_next;
      end
    end
  end

endmodule

// File: rtl/efc_sample_fifo.sv
module efc_sample_fifo
  import efc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int LVL_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              pop,
  output logic              bist_busy,
  output logic              bist_fail
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W:0]   wptr, rptr;
  logic [ADDR_W+1:0] bcnt;
  logic [ADDR_W-1:0] baddr;
  logic [WORD_W-1:0] bpat;
  logic              bist_wr, bist_rd, pend_q, pending;

  assign level = wptr - rptr;
  assign full  = (level == LVL_W'(DEPTH));

  // self-test: write phase over all addresses, then read-back phase
  assign bist_busy = !bcnt[ADDR_W+1];
  assign bist_wr   = bist_busy && !bcnt[ADDR_W];
  assign bist_rd   = bist_busy &&  bcnt[ADDR_W];
  assign baddr     = bcnt[ADDR_W-1:0];
  assign bpat      = bist_pattern(8'(baddr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt      <= '0;
      bist_fail <= 1'b0;
    end else begin
      if (bist_busy) bcnt <= bcnt + 1'b1;
      if (bist_rd && (mem[baddr] != bpat)) bist_fail <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (bist_wr)              mem[baddr] <= bpat;
    else if (push && !clear)  mem[wptr[ADDR_W-1:0]] <= push_data;
  end

  // read side: a request waits until a word is present
  assign pending = pend_q || rd_req;
  assign pop     = pending && (level != '0) && !clear && !bist_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      pend_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (clear) begin
      wptr     <= '0;
      rptr     <= '0;
      pend_q   <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      pend_q   <= pending && !pop;
      rd_valid <= pop;
      if (pop) rd_data <= mem[rptr[ADDR_W-1:0]];
    end
  end

endmodule

// File: rtl/entropy_fifo_ctrl.sv
module entropy_fifo_ctrl
  import efc_pkg::*;
#(
  parameter int N_OSC       = 128,
  parameter int GROUP_W     = 8,
  parameter int DEPTH       = 64,
  parameter int COND_CYCLES = 81,
  localparam int GRP_IDX_W  = $clog2(N_OSC / GROUP_W),
  localparam int LVL_W      = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_en,
  input  logic [1:0]           ctl_mode,
  input  logic [GRP_IDX_W-1:0] ctl_group,
  input  logic                 core_rst,
  input  logic [N_OSC-1:0]     osc_in,
  input  logic                 rd_req,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 rd_valid,
  output logic [1:0]           bist_status
);

  efc_mode_e         mode;
  logic              osc_on, osc_live, run, push, pop, restart;
  logic              fifo_full, bist_busy, bist_fail;
  logic [N_OSC-1:0]  sample;
  logic [WORD_W-1:0] push_data;
  logic [LVL_W-1:0]  fifo_level;

  assign mode   = efc_mode_e'(ctl_mode);
  assign osc_on = ctl_en && ((mode == MODE_COND) || (mode == MODE_RAW))
                  && !bist_busy && !core_rst;
  assign run    = ctl_en && (mode != MODE_OFF) && !bist_busy && !core_rst && !fifo_full;

  efc_osc_sampler #(.N_OSC(N_OSC)) u_smp (
    .clk(clk), .rst_n(rst_n), .osc_on(osc_on), .osc_in(osc_in),
    .sample(sample), .osc_live(osc_live)
  );

  efc_entry_builder #(
    .N_OSC(N_OSC), .GROUP_W(GROUP_W), .COND_CYCLES(COND_CYCLES), .GRP_IDX_W(GRP_IDX_W)
  ) u_bld (
    .clk(clk), .rst_n(rst_n), .clear(core_rst), .run(run), .mode(mode),
    .group(ctl_group), .sample(sample), .push(push), .push_data(push_data),
    .restart(restart)
  );

  efc_sample_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(core_rst), .push(push), .push_data(push_data),
    .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .level(fifo_level),
    .full(fifo_full), .pop(pop), .bist_busy(bist_busy), .bist_fail(bist_fail)
  );

  assign bist_status = {bist_busy, bist_fail};

endmodule

// File: rtl/efc_checker.sv
module efc_checker #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_rst,
  input logic             ctl_en,
  input logic [1:0]       ctl_mode,
  input logic             push,
  input logic             pop,
  input logic             rd_valid,
  input logic [LVL_W-1:0] level,
  input logic             bist_busy,
  input logic             restart,
  input logic             osc_live
);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  a_r6_full_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH)) |-> !push);

  a_r7_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !core_rst) |=> (level == $past(level) + LVL_W'(1)));

  a_r8_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (level != '0));

  a_r8_valid_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(pop));

  a_r9_core_rst_empties: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (level == '0) && !rd_valid && !osc_live);

  a_r1_quiet_during_bist: assert property (@(posedge clk) disable iff (!rst_n)
    bist_busy |-> (!push && !pop));

  a_r10_restart_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !push);

  a_r11_idle_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en || (ctl_mode == 2'b11)) |-> !push);

endmodule

bind entropy_fifo_ctrl efc_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
  .push(push), .pop(pop), .rd_valid(rd_valid), .level(fifo_level),
  .bist_busy(bist_busy), .restart(restart), .osc_live(osc_live)
);

// File: tb/sim_entropy_fifo_ctrl.sv
`timescale 1ns/1ps
module sim_entropy_fifo_ctrl;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctl_en = 1'b0;
  logic [1:0]   ctl_mode = 2'b11;
  logic [3:0]   ctl_group = '0;
  logic         core_rst = 1'b0;
  logic [127:0] osc_in = '0;
  logic         rd_req = 1'b0;
  logic [63:0]  rd_data;
  logic         rd_valid;
  logic [1:0]   bist_status;

  int checks = 0;
  int failures = 0;
  logic [127:0] oscv [0:255];

  always #2.5 clk = ~clk;

  entropy_fifo_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_mode(ctl_mode), .ctl_group(ctl_group),
    .core_rst(core_rst), .osc_in(osc_in), .rd_req(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .bist_status(bist_status)
  );

  localparam logic [63:0] SEED = 64'h6A09E667F3BCC908;
  localparam logic [63:0] KEY  = 64'h9E3779B97F4A7C15;

  function automatic logic [63:0] b_step(logic [63:0] a, logic [127:0] s);
    logic [63:0] r;
    r = (a << 5) | (a >> 59);
    return r ^ KEY ^ s[127:64] ^ s[63:0];
  endfunction

  function automatic logic [63:0] b_cond(bit first, bit det, int base);
    logic [63:0] a = SEED;
    for (int t = 0; t < 81; t++) begin
      if (det || (first && t == 0)) a = b_step(a, '0);
      else                          a = b_step(a, oscv[base+t]);
    end
    return a;
  endfunction

  function automatic logic [63:0] b_raw(int g, int base, bit first);
    logic [63:0] w = '0;
    for (int k = 0; k < 8; k++)
      for (int t = 0; t < 8; t++)
        w[k*8+t] = (first && t == 0) ? 1'b0 : oscv[base+t][g*8+k];
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_tab(int n);
    for (int i = 0; i < n; i++) oscv[i] = {$urandom, $urandom, $urandom, $urandom};
  endtask

  // one table sample per cycle; optional mode/group switch and core reset at given steps
  task automatic drive(int n, int sw_at, logic [1:0] sw_mode, logic [3:0] sw_grp, int cr_at);
    for (int t = 0; t < n; t++) begin
      if (t == sw_at) begin ctl_mode = sw_mode; ctl_group = sw_grp; end
      core_rst = (t == cr_at);
      osc_in = oscv[t];
      @(negedge clk);
    end
    core_rst = 1'b0;
  endtask

  task automatic idle(int n);
    for (int t = 0; t < n; t++) begin
      osc_in = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
    end
  endtask

  task automatic do_core_rst();
    core_rst = 1'b1;
    @(negedge clk);
    core_rst = 1'b0;
  endtask

  task automatic read_word(output bit got, output logic [63:0] d, input int wait_max);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    got = 1'b0;
    d = '0;
    for (int i = 0; i < wait_max; i++) begin
      if (rd_valid) begin got = 1'b1; d = rd_data; break; end
      @(negedge clk);
    end
  endtask

  task automatic drain(output int n);
    bit got;
    logic [63:0] d;
    n = 0;
    do begin
      read_word(got, d, 4);
      if (got) n++;
    end while (got && n < 200);
    do_core_rst();
  endtask

  task automatic expect_empty(string req);
    bit got;
    logic [63:0] d;
    read_word(got, d, 20);
    chk(!got, req, {63'd0, got}, 64'd0);
    do_core_rst();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit got;
    logic [63:0] d, e;
    int n, nv, g, g2;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: self-test window
    chk(bist_status == 2'b10 && !rd_valid, "R1 busy after reset", {62'd0, bist_status}, 64'd2);
    n = 0;
    while (bist_status[1] && n < 400) begin n++; @(negedge clk); end
    chk(n == 128, "R1 self-test length", 64'(n), 64'd128);
    chk(bist_status == 2'b00, "R1 status passes", {62'd0, bist_status}, 64'd0);

    // R8: read from empty stalls, then served when first deterministic word lands
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    nv = 0;
    for (int i = 0; i < 20; i++) begin if (rd_valid) nv++; @(negedge clk); end
    chk(nv == 0, "R8 no valid while empty", 64'(nv), 64'd0);
    ctl_mode = 2'b00; ctl_en = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!rd_valid && n < 300);
    e = b_cond(1'b0, 1'b1, 0);
    chk(n == 82, "R8/R2 stalled read served after 81-cycle word", 64'(n), 64'd82);
    chk(rd_data == e, "R2 deterministic word", rd_data, e);
    read_word(got, d, 200);
    chk(got && d == e, "R2 deterministic word repeats", d, e);
    ctl_en = 1'b0; @(negedge clk); do_core_rst();

    // R3/R5: conditioned word from fresh oscillators
    fill_tab(81);
    ctl_mode = 2'b01; ctl_en = 1'b1;
    drive(81, -1, 2'b00, 4'd0, -1);
    ctl_en = 1'b0;
    e = b_cond(1'b1, 1'b0, 0);
    read_word(got, d, 10);
    chk(got && d == e, "R3 conditioned word", d, e);
    expect_empty("R3 exactly one conditioned word");

    // R4/R5/R7: raw mode, random groups, two consecutive words in order
    for (int it = 0; it < 6; it++) begin
      g = (it == 0) ? 15 : int'($urandom_range(0, 15));
      fill_tab(16);
      ctl_mode = 2'b10; ctl_group = 4'(g); ctl_en = 1'b1;
      drive(16, -1, 2'b00, 4'd0, -1);
      ctl_en = 1'b0;
      read_word(got, d, 10);
      e = b_raw(g, 0, 1'b1);
      chk(got && d == e, "R4 raw word lanes", d, e);
      chk((d & 64'h0101010101010101) == 64'd0, "R5 first sample zero", d & 64'h0101010101010101, 64'd0);
      read_word(got, d, 10);
      e = b_raw(g, 8, 1'b0);
      chk(got && d == e, "R7 second raw word in order", d, e);
      expect_empty("R4 two raw words only");
    end

    // R10: group change mid-word in raw mode
    g = int'($urandom_range(0, 15)); g2 = (g + 5) % 16;
    fill_tab(12);
    ctl_mode = 2'b10; ctl_group = 4'(g); ctl_en = 1'b1;
    drive(12, 4, 2'b10, 4'(g2), -1);
    ctl_en = 1'b0;
    read_word(got, d, 10);
    e = b_raw(g2, 4, 1'b0);
    chk(got && d == e, "R10 group change restarts word", d, e);
    expect_empty("R10 partial word discarded");

    // R10: mode change conditioned -> raw mid-word
    fill_tab(48);
    ctl_mode = 2'b01; ctl_group = 4'd3; ctl_en = 1'b1;
    drive(48, 40, 2'b10, 4'd3, -1);
    ctl_en = 1'b0;
    read_word(got, d, 10);
    e = b_raw(3, 40, 1'b0);
    chk(got && d == e, "R10 mode change restarts word", d, e);
    expect_empty("R10 conditioned partial dropped");

    // R9: core reset mid-word drops partial and re-arms first-zero sample
    fill_tab(13);
    ctl_mode = 2'b10; ctl_group = 4'd9; ctl_en = 1'b1;
    drive(13, -1, 2'b00, 4'd0, 4);
    ctl_en = 1'b0;
    read_word(got, d, 10);
    e = b_raw(9, 5, 1'b1);
    chk(got && d == e, "R9 core reset drops partial word", d, e);
    expect_empty("R9 one word after core reset");

    // R9: core reset empties a loaded buffer
    ctl_mode = 2'b10; ctl_en = 1'b1; idle(40); ctl_en = 1'b0;
    @(negedge clk);
    do_core_rst();
    expect_empty("R9 core reset empties buffer");

    // R11: idle code and disabled state produce nothing
    ctl_mode = 2'b11; ctl_en = 1'b1; idle(100); ctl_en = 1'b0;
    expect_empty("R11 mode 11 idle");
    ctl_mode = 2'b10; ctl_en = 1'b0; idle(100);
    expect_empty("R11 enable low");

    // R6: fill stops at 64
    ctl_mode = 2'b10; ctl_en = 1'b1; idle(600); ctl_en = 1'b0;
    drain(n);
    chk(n == 64, "R6 buffer holds 64 words", 64'(n), 64'd64);

    // R7: reads trigger background refill
    ctl_en = 1'b1; idle(600);
    for (int i = 0; i < 5; i++) begin read_word(got, d, 4); end
    idle(100); ctl_en = 1'b0;
    drain(n);
    chk(n == 64, "R7 refill after reads", 64'(n), 64'd64);

    // R6/R7: pops and pushes in the same cycle from a full buffer
    ctl_en = 1'b1; idle(600);
    rd_req = 1'b1; nv = 0;
    for (int i = 0; i < 100; i++) begin
      osc_in = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
      if (rd_valid) nv++;
    end
    rd_req = 1'b0; ctl_en = 1'b0;
    for (int i = 0; i < 4; i++) begin if (rd_valid) nv++; @(negedge clk); end
    drain(n);
    chk(nv + n == 76, "R7 concurrent push and pop total", 64'(nv + n), 64'd76);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule